// File: doc/BRIEF.md
# Retired-Event Sampling Counter

This block is a small performance-monitoring unit. Each cycle the core presents up to two retirement lanes (valid, code address, mispredicted-branch flag) and a halted flag. Work the core discards after a misprediction or fault never shows up on these lanes, so every event counted here is a retired one. Software picks one event: unhalted cycles, retired instructions or retired mispredicted branches. It then programs the counting direction, reload value, threshold and sampling mode, and reads the live count back at any time.

When the count runs out, the block records one code address for the event. For the cycles event, which has no instruction of its own, that is the youngest instruction retiring in the same cycle, or the last one that retired before it. In interrupt mode the address is latched and a level interrupt is raised. In buffer mode a record {event, address, timestamp} is written through a write port into a ring-less buffer that is bounded by a base and a limit. Writing stops once the buffer is full, and a buffer-full interrupt is raised.

Register map (cfg address, 4 bits): 0 control, 1 reload, 2 threshold, 3 count (read/write), 4 buffer base, 5 buffer limit, 6 write pointer (read), 7 status (write 1 to clear), 8 sampled address (read), 9 timestamp (read). Control bits: bit 0 enable, bit 1 up-count (0 = down), bit 2 buffer mode (0 = interrupt), bits 5:4 event (0 unhalted cycles, 1 retired instructions, 2 retired mispredicts, 3 none). Status: bit 0 overflow pending, bit 1 buffer-full pending.

Top module: `retire_event_sampler`

## Requirements
- R1: After reset the control register, count, status, interrupt and memory write strobe all read 0.
- R2: With event 1 and enable set, the count rises by the number of valid retirement lanes in each cycle (0, 1 or 2). With enable clear, it does not change.
- R3: With event 0, the count rises by one in each cycle in which the halted input is low, and it does not rise in halted cycles.
- R4: With event 2, the count rises by the number of lanes whose valid and mispredict flags are both high. A mispredict flag on a lane without valid is ignored.
- R5: In down mode a cycle with increment n fires when the count is at most n. The count is then loaded with the reload value; otherwise it drops by n.
- R6: In up mode a cycle fires when count plus increment reaches at least the threshold, and the count is then loaded with the reload value.
- R7: In interrupt mode (control bit 2 = 0) a firing sets status bit 0 and latches the sampled address. irq_o stays high until software writes 1 to status bit 0.
- R8: In buffer mode a firing writes {event[1:0], address, timestamp[TSW-1:0]} at the write pointer on the cycle after the firing edge, the pointer advances by one, and status bit 0 is not set; writing the base register sets the pointer to it.
- R9: The write that brings the pointer to the limit sets status bit 1 and irq_o; later firings write nothing until the base is written again. Writing 1 to status bit 1 drops the interrupt.
- R10: The sampled address is the youngest qualifying lane of the firing cycle. For the cycles event with no retirement in that cycle, it is the last retired address.
- R11: A write to the count register takes effect on the next cycle and reads back at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halted_i | input | 1 | Core is halted this cycle |
| ret0_vld_i | input | 1 | Older lane retires an instruction |
| ret0_pc_i | input | DW | Older lane code address |
| ret0_misp_i | input | 1 | Older lane was a mispredicted branch |
| ret1_vld_i | input | 1 | Younger lane retires an instruction |
| ret1_pc_i | input | DW | Younger lane code address |
| ret1_misp_i | input | 1 | Younger lane was a mispredicted branch |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register write address |
| cfg_wdata_i | input | DW | Register write data |
| cfg_raddr_i | input | 4 | Register read address |
| cfg_rdata_o | output | DW | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt: overflow or buffer full pending |
| mem_we_o | output | 1 | Sample record write strobe |
| mem_addr_o | output | DW | Sample record address |
| mem_wdata_o | output | 2+DW+TSW | Sample record |

## Verification
The properties watch, on every cycle, invariants that hold whatever the event stream is. The increment never exceeds two and is zero for halted cycles or lanes that do not retire. A down count that did not fire strictly decreases, and an up count that did not fire stays below the threshold. Every firing reloads the count. A pending overflow stays high until it is cleared, and no record is written while the buffer is full. Which address a sample carries, the exact record contents and timestamp, where the interrupt and buffer modes split, and the full sequence up to the limit depend on particular stimulus, so only the bench's directed scenarios show them.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    typedef enum logic [1:0] {
        EV_CYCLES = 2'd0,
        EV_INSTR  = 2'd1,
        EV_MISP   = 2'd2,
        EV_NONE   = 2'd3
    } ev_sel_e;

    localparam logic [3:0] RA_CTRL   = 4'd0;
    localparam logic [3:0] RA_RELOAD = 4'd1;
    localparam logic [3:0] RA_THRESH = 4'd2;
    localparam logic [3:0] RA_COUNT  = 4'd3;
    localparam logic [3:0] RA_BASE   = 4'd4;
    localparam logic [3:0] RA_LIMIT  = 4'd5;
    localparam logic [3:0] RA_WPTR   = 4'd6;
    localparam logic [3:0] RA_STATUS = 4'd7;
    localparam logic [3:0] RA_SPC    = 4'd8;
    localparam logic [3:0] RA_TS     = 4'd9;
endpackage

// File: rtl/pmu_event_sel.sv
module pmu_event_sel
    import pmu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  ev_sel_e       sel_i,
    input  logic          halted_i,
    input  logic          v0_i,
    input  logic [DW-1:0] p0_i,
    input  logic          m0_i,
    input  logic          v1_i,
    input  logic [DW-1:0] p1_i,
    input  logic          m1_i,
    output logic [1:0]    inc_o,
    output logic [DW-1:0] pc_o
);
    typedef struct packed {
        logic [DW-1:0] last_pc;
    } st_t;

    st_t st_d, st_q;
    logic [1:0]    n_ret, n_misp;
    logic [DW-1:0] young_ret_pc, young_misp_pc;

    always_comb begin
        st_d          = st_q;
        n_ret         = {1'b0, v0_i} + {1'b0, v1_i};
        n_misp        = {1'b0, v0_i & m0_i} + {1'b0, v1_i & m1_i};
        young_ret_pc  = v1_i ? p1_i : (v0_i ? p0_i : st_q.last_pc);
        young_misp_pc = (v1_i & m1_i) ? p1_i : p0_i;
        inc_o         = 2'd0;
        pc_o          = young_ret_pc;
        case (sel_i)
            EV_CYCLES: inc_o = {1'b0, ~halted_i};
            EV_INSTR:  inc_o = n_ret;
            EV_MISP: begin
                inc_o = n_misp;
                pc_o  = young_misp_pc;
            end
            default:   inc_o = 2'd0;
        endcase
        if (v0_i | v1_i) st_d.last_pc = young_ret_pc;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    p_inc_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inc_o != 2'd3);
    p_halted_no_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == EV_CYCLES && halted_i) |-> inc_o == 2'd0);
    p_misp_needs_retire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == EV_MISP && !v0_i && !v1_i) |-> inc_o == 2'd0);
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int CW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic          up_i,
    input  logic [1:0]    inc_i,
    input  logic [CW-1:0] reload_i,
    input  logic [CW-1:0] thresh_i,
    input  logic          wr_i,
    input  logic [CW-1:0] wdata_i,
    output logic [CW-1:0] count_o,
    output logic          fire_o
);
    typedef struct packed {
        logic [CW-1:0] count;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] incw, sum;

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        incw   = CW'(inc_i);
        sum    = st_q.count + incw;
        if (en_i && inc_i != 2'd0) begin
            if (up_i) begin
                if (sum >= thresh_i) begin
                    fire_o     = 1'b1;
                    st_d.count = reload_i;
                end else begin
                    st_d.count = sum;
                end
            end else begin
                if (st_q.count <= incw) begin
                    fire_o     = 1'b1;
                    st_d.count = reload_i;
                end else begin
                    st_d.count = st_q.count - incw;
                end
            end
        end
        if (wr_i) st_d.count = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o = st_q.count;

    p_down_decreases_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !up_i && inc_i != 2'd0 && !fire_o && !wr_i) |=> st_q.count < $past(st_q.count));
    p_up_below_thresh_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && up_i && inc_i != 2'd0 && !fire_o && !wr_i) |=> st_q.count < $past(thresh_i));
    p_fire_reloads_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire_o && !wr_i) |=> st_q.count == $past(reload_i));
endmodule

// File: rtl/pmu_sample_buf.sv
module pmu_sample_buf #(
    parameter int DW  = 32,
    parameter int TSW = 16,
    localparam int RECW = 2 + DW + TSW
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            fire_i,
    input  logic [1:0]      ev_i,
    input  logic [DW-1:0]   pc_i,
    input  logic [TSW-1:0]  ts_i,
    input  logic            base_wr_i,
    input  logic [DW-1:0]   base_i,
    input  logic [DW-1:0]   limit_i,
    output logic            mem_we_o,
    output logic [DW-1:0]   mem_addr_o,
    output logic [RECW-1:0] mem_wdata_o,
    output logic [DW-1:0]   wptr_o,
    output logic            full_set_o
);
    typedef struct packed {
        logic [DW-1:0]   wptr;
        logic            full;
        logic            we;
        logic [DW-1:0]   addr;
        logic [RECW-1:0] data;
    } st_t;

    st_t st_d, st_q;
    logic [DW-1:0] nxt_ptr;

    always_comb begin
        st_d       = st_q;
        st_d.we    = 1'b0;
        full_set_o = 1'b0;
        nxt_ptr    = st_q.wptr + 1'b1;
        if (fire_i && !st_q.full) begin
            st_d.we   = 1'b1;
            st_d.addr = st_q.wptr;
            st_d.data = {ev_i, pc_i, ts_i};
            st_d.wptr = nxt_ptr;
            if (nxt_ptr >= limit_i) begin
                st_d.full  = 1'b1;
                full_set_o = 1'b1;
            end
        end
        if (base_wr_i) begin
            st_d.wptr = base_i;
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mem_we_o    = st_q.we;
    assign mem_addr_o  = st_q.addr;
    assign mem_wdata_o = st_q.data;
    assign wptr_o      = st_q.wptr;

    p_no_write_when_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.full |=> !st_q.we);
    p_wptr_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire_i && !st_q.full && !base_wr_i) |=> (st_q.we && st_q.wptr == $past(st_q.wptr) + 1'b1));
endmodule

// File: rtl/retire_event_sampler.sv
module retire_event_sampler
    import pmu_pkg::*;
#(
    parameter int DW  = 32,
    parameter int TSW = 16
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  halted_i,
    input  logic                  ret0_vld_i,
    input  logic [DW-1:0]         ret0_pc_i,
    input  logic                  ret0_misp_i,
    input  logic                  ret1_vld_i,
    input  logic [DW-1:0]         ret1_pc_i,
    input  logic                  ret1_misp_i,
    input  logic                  cfg_we_i,
    input  logic [3:0]            cfg_addr_i,
    input  logic [DW-1:0]         cfg_wdata_i,
    input  logic [3:0]            cfg_raddr_i,
    output logic [DW-1:0]         cfg_rdata_o,
    output logic                  irq_o,
    output logic                  mem_we_o,
    output logic [DW-1:0]         mem_addr_o,
    output logic [2+DW+TSW-1:0]   mem_wdata_o
);
    typedef struct packed {
        logic          en;
        logic          up;
        logic          bufm;
        ev_sel_e       ev;
        logic [DW-1:0] reload;
        logic [DW-1:0] thresh;
        logic [DW-1:0] base;
        logic [DW-1:0] limit;
        logic          ovf_pend;
        logic          full_pend;
        logic [DW-1:0] spc;
        logic [TSW-1:0] ts;
    } st_t;

    st_t st_d, st_q;

    logic [1:0]    inc;
    logic [DW-1:0] sel_pc, count, wptr;
    logic          fire, full_set, cnt_wr, base_wr, status_wr;

    assign cnt_wr    = cfg_we_i && cfg_addr_i == RA_COUNT;
    assign base_wr   = cfg_we_i && cfg_addr_i == RA_BASE;
    assign status_wr = cfg_we_i && cfg_addr_i == RA_STATUS;

    pmu_event_sel #(.DW(DW)) u_sel (
        .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(st_q.ev), .halted_i(halted_i),
        .v0_i(ret0_vld_i), .p0_i(ret0_pc_i), .m0_i(ret0_misp_i),
        .v1_i(ret1_vld_i), .p1_i(ret1_pc_i), .m1_i(ret1_misp_i),
        .inc_o(inc), .pc_o(sel_pc)
    );

    pmu_counter #(.CW(DW)) u_cnt (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(st_q.en), .up_i(st_q.up),
        .inc_i(inc), .reload_i(st_q.reload), .thresh_i(st_q.thresh),
        .wr_i(cnt_wr), .wdata_i(cfg_wdata_i), .count_o(count), .fire_o(fire)
    );

    pmu_sample_buf #(.DW(DW), .TSW(TSW)) u_buf (
        .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire && st_q.bufm),
        .ev_i(st_q.ev), .pc_i(sel_pc), .ts_i(st_q.ts),
        .base_wr_i(base_wr), .base_i(cfg_wdata_i), .limit_i(st_q.limit),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .wptr_o(wptr), .full_set_o(full_set)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ts = st_q.ts + 1'b1;
        if (cfg_we_i) begin
            case (cfg_addr_i)
                RA_CTRL: begin
                    st_d.en   = cfg_wdata_i[0];
                    st_d.up   = cfg_wdata_i[1];
                    st_d.bufm = cfg_wdata_i[2];
                    st_d.ev   = ev_sel_e'(cfg_wdata_i[5:4]);
                end
                RA_RELOAD: st_d.reload = cfg_wdata_i;
                RA_THRESH: st_d.thresh = cfg_wdata_i;
                RA_BASE:   st_d.base   = cfg_wdata_i;
                RA_LIMIT:  st_d.limit  = cfg_wdata_i;
                RA_STATUS: begin
                    if (cfg_wdata_i[0]) st_d.ovf_pend  = 1'b0;
                    if (cfg_wdata_i[1]) st_d.full_pend = 1'b0;
                end
                default: ;
            endcase
        end
        if (fire) begin
            st_d.spc = sel_pc;
            if (!st_q.bufm) st_d.ovf_pend = 1'b1;
        end
        if (full_set) st_d.full_pend = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        cfg_rdata_o = '0;
        case (cfg_raddr_i)
            RA_CTRL:   cfg_rdata_o = DW'({st_q.ev, 1'b0, st_q.bufm, st_q.up, st_q.en});
            RA_RELOAD: cfg_rdata_o = st_q.reload;
            RA_THRESH: cfg_rdata_o = st_q.thresh;
            RA_COUNT:  cfg_rdata_o = count;
            RA_BASE:   cfg_rdata_o = st_q.base;
            RA_LIMIT:  cfg_rdata_o = st_q.limit;
            RA_WPTR:   cfg_rdata_o = wptr;
            RA_STATUS: cfg_rdata_o = DW'({st_q.full_pend, st_q.ovf_pend});
            RA_SPC:    cfg_rdata_o = st_q.spc;
            RA_TS:     cfg_rdata_o = DW'(st_q.ts);
            default:   cfg_rdata_o = '0;
        endcase
    end

    assign irq_o = st_q.ovf_pend | st_q.full_pend;

    p_irq_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ovf_pend && !(status_wr && cfg_wdata_i[0])) |=> st_q.ovf_pend);
    p_buf_mode_no_ovf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.ovf_pend && st_q.bufm && !(cfg_we_i && cfg_addr_i == RA_CTRL)) |=> !st_q.ovf_pend);
endmodule

// File: tb/retire_event_sampler_tb_top.sv
module retire_event_sampler_tb_top;
    localparam int DW = 32;
    localparam int TSW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halted = 1'b1;
    logic v0 = 0, m0 = 0, v1 = 0, m1 = 0;
    logic [DW-1:0] p0 = '0, p1 = '0;
    logic cfg_we = 0;
    logic [3:0] cfg_addr = '0, cfg_raddr = '0;
    logic [DW-1:0] cfg_wdata = '0, cfg_rdata;
    logic irq, mem_we;
    logic [DW-1:0] mem_addr;
    logic [2+DW+TSW-1:0] mem_wdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    retire_event_sampler #(.DW(DW), .TSW(TSW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .halted_i(halted),
        .ret0_vld_i(v0), .ret0_pc_i(p0), .ret0_misp_i(m0),
        .ret1_vld_i(v1), .ret1_pc_i(p1), .ret1_misp_i(m1),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .cfg_raddr_i(cfg_raddr), .cfg_rdata_o(cfg_rdata), .irq_o(irq),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
    );

    task automatic chk(string req, longint got, longint exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [DW-1:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [DW-1:0] d);
        cfg_raddr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic cyc(logic a0, logic [DW-1:0] q0, logic b0,
                       logic a1, logic [DW-1:0] q1, logic b1, logic h);
        v0 = a0; p0 = q0; m0 = b0; v1 = a1; p1 = q1; m1 = b1; halted = h;
        @(negedge clk);
        v0 = 0; v1 = 0; m0 = 0; m1 = 0; halted = 1;
    endtask

    task automatic t_reset;
        logic [DW-1:0] d;
        rd(4'd0, d); chk("R1 ctrl", d, 0);
        rd(4'd3, d); chk("R1 count", d, 0);
        rd(4'd7, d); chk("R1 status", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 mem_we", mem_we, 0);
    endtask

    task automatic t_instr_count;
        logic [DW-1:0] d;
        wr(4'd2, 1000);
        wr(4'd3, 100);
        rd(4'd3, d); chk("R11 count write", d, 100);
        wr(4'd0, 32'h13);
        cyc(1, 1, 0, 0, 0, 0, 1);
        cyc(1, 2, 0, 1, 3, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 1, 4, 0, 1);
        rd(4'd3, d); chk("R2 lanes 1+2+0+1", d, 104);
        wr(4'd0, 32'h12);
        cyc(1, 5, 0, 1, 6, 0, 1);
        rd(4'd3, d); chk("R2 disabled", d, 104);
    endtask

    task automatic t_cycles;
        logic [DW-1:0] d;
        wr(4'd3, 0);
        wr(4'd0, 32'h03);
        repeat (3) cyc(0, 0, 0, 0, 0, 0, 0);
        repeat (2) cyc(0, 0, 0, 0, 0, 0, 1);
        wr(4'd0, 32'h02);
        rd(4'd3, d); chk("R3 unhalted cycles", d, 3);
    endtask

    task automatic t_misp;
        logic [DW-1:0] d;
        wr(4'd3, 0);
        wr(4'd0, 32'h23);
        cyc(1, 8, 1, 0, 0, 0, 1);
        cyc(1, 9, 0, 1, 10, 1, 1);
        cyc(0, 0, 1, 0, 0, 1, 1);
        cyc(1, 11, 1, 1, 12, 1, 1);
        wr(4'd0, 32'h22);
        rd(4'd3, d); chk("R4 retired mispredicts", d, 4);
    endtask

    task automatic t_down_irq;
        logic [DW-1:0] d;
        wr(4'd1, 3);
        wr(4'd3, 3);
        wr(4'd0, 32'h11);
        cyc(1, 32'h1000, 0, 0, 0, 0, 1);
        cyc(1, 32'h1004, 0, 0, 0, 0, 1);
        chk("R5 no fire before zero", irq, 0);
        rd(4'd3, d); chk("R5 count 1", d, 1);
        cyc(1, 32'h1008, 0, 1, 32'h100c, 0, 1);
        chk("R7 irq set", irq, 1);
        rd(4'd3, d); chk("R5 reload", d, 3);
        rd(4'd8, d); chk("R10 youngest lane", d, 32'h100c);
        repeat (2) @(negedge clk);
        chk("R7 irq held", irq, 1);
        rd(4'd7, d); chk("R7 status bit0", d, 1);
        wr(4'd7, 1);
        chk("R7 irq cleared", irq, 0);
        wr(4'd0, 0);
    endtask

    task automatic t_up;
        logic [DW-1:0] d;
        wr(4'd2, 5);
        wr(4'd1, 0);
        wr(4'd3, 0);
        wr(4'd0, 32'h13);
        cyc(1, 1, 0, 1, 2, 0, 1);
        cyc(1, 3, 0, 1, 4, 0, 1);
        chk("R6 below threshold", irq, 0);
        cyc(1, 5, 0, 1, 6, 0, 1);
        chk("R6 fire at threshold", irq, 1);
        rd(4'd3, d); chk("R6 reload", d, 0);
        wr(4'd7, 1);
        wr(4'd2, 2);
        wr(4'd0, 32'h03);
        cyc(1, 32'h2000, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R6 cycles fire", irq, 1);
        rd(4'd8, d); chk("R10 last retired pc", d, 32'h2000);
        wr(4'd7, 1);
        wr(4'd0, 0);
    endtask

    task automatic t_buffer;
        logic [DW-1:0] d, t;
        wr(4'd1, 1);
        wr(4'd3, 1);
        wr(4'd4, 32'h100);
        wr(4'd5, 32'h102);
        wr(4'd0, 32'h15);
        rd(4'd9, t);
        cyc(1, 32'h40, 0, 0, 0, 0, 1);
        chk("R8 write strobe", mem_we, 1);
        chk("R8 addr", mem_addr, 32'h100);
        chk("R8 record", mem_wdata, {2'd1, 32'h40, t[TSW-1:0]});
        chk("R8 no ovf irq", irq, 0);
        rd(4'd6, d); chk("R8 wptr", d, 32'h101);
        cyc(1, 32'h44, 0, 0, 0, 0, 1);
        chk("R9 last write", mem_we, 1);
        chk("R9 last addr", mem_addr, 32'h101);
        chk("R9 full irq", irq, 1);
        rd(4'd7, d); chk("R9 status bit1", d, 2);
        cyc(1, 32'h48, 0, 0, 0, 0, 1);
        chk("R9 no write when full", mem_we, 0);
        rd(4'd6, d); chk("R9 wptr held", d, 32'h102);
        wr(4'd7, 2);
        chk("R9 irq cleared", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_instr_count();
        t_cycles();
        t_misp();
        t_down_irq();
        t_up();
        t_buffer();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule